// File: doc/BRIEF.md
# Crosswise Multiply-Accumulate Unit

This block is the multiply and multiply-accumulate path of a small processor ALU. It takes two unsigned 16-bit operands and forms their full 32-bit product with the vertical-and-crosswise method. There is no shift-add loop and no behavioural multiply operator. A 2x2 base cell forms the column sums of its digit pairs, including the crosswise carry. Each larger stage then combines four half-width sub-products: the low-by-low term, the two mixed terms added and shifted up by half the stage width, and the high-by-high term shifted up by the full stage width. The recursion goes from 2x2 to 4x4, 8x8 and 16x16.

The product passes through one register stage. On a valid cycle the product register is loaded, and an output-valid flag pulses one cycle later. If the accumulate enable is also high in that cycle, the new product is added into a 32-bit accumulator, which wraps on overflow. A clear input zeroes the accumulator on any cycle and wins over a simultaneous accumulate.

Top module: `urdhvaMac`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and on the first cycle after it is released, `product`, `accum` and `outValid` are all zero.
- R2: When `inValid` is high at a clock edge, `product` shows the unsigned 32-bit product of `opA` and `opB` after that edge, and `outValid` is high for exactly the cycles that follow a valid cycle.
- R3: When `inValid` is low at a clock edge, `product` keeps its previous value.
- R4: When `inValid` and `accEn` are both high and `accClear` is low at an edge, `accum` becomes its old value plus the product of the current operands, taken modulo 2^32.
- R5: When `inValid` is high and `accEn` is low (with `accClear` low), `accum` is unchanged.
- R6: When `accClear` is high at an edge, `accum` is zero after it. This holds even when an accumulate is requested in the same cycle, and `product` is still loaded if `inValid` is high.
- R7: `accEn` has no effect while `inValid` is low: `accum` and `product` both hold.
- R8: Corner operands produce exact products: 252 x 846 = 213192, 0xFFFF x 0xFFFF = 0xFFFE0001, and any operand times 0 gives 0.
- R9: The accumulator wraps on overflow. Three accumulations of 0xFFFF x 0xFFFF from zero leave 0xFFFA0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | Multiplicand, unsigned |
| opB | input | 16 | Multiplier, unsigned |
| inValid | input | 1 | Operand strobe; loads the product register |
| accEn | input | 1 | Add the product into the accumulator on a valid cycle |
| accClear | input | 1 | Zero the accumulator; priority over accumulate |
| product | output | 32 | Registered product of the last valid operands |
| accum | output | 32 | Accumulator value |
| outValid | output | 1 | High in the cycle after a valid strobe |

## Verification
The two functions that can fall in the same cycle are a clear and an accumulate. The bench raises `accClear` together with `inValid` and `accEn`, both in directed cases and in a randomized stream where all three inputs toggle independently. The result is judged against a behavioural reference model updated on every edge. That model expects a zero accumulator after such a cycle and a freshly loaded product register.

// File: rtl/urdhvaMacPkg.sv
package urdhvaMacPkg;
  localparam int OPERAND_W = 16;
  localparam int RESULT_W  = 2 * OPERAND_W;

  typedef struct packed {
    logic loadProd;
    logic addAcc;
    logic zeroAcc;
  } macStrobes_t;
endpackage

// File: rtl/crossCell2.sv
// 2x2 base cell: column 0 is the vertical pair, column 1 the crosswise pair,
// column 2 the high vertical pair plus the carry out of column 1.
module crossCell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic crossX, crossY, crossSum, crossCarry, highTerm;

  always_comb begin
    crossX     = a[1] & b[0];
    crossY     = a[0] & b[1];
    crossSum   = crossX ^ crossY;
    crossCarry = crossX & crossY;
    highTerm   = a[1] & b[1];
    p[0]       = a[0] & b[0];
    p[1]       = crossSum;
    p[2]       = highTerm ^ crossCarry;
    p[3]       = highTerm & crossCarry;
  end
endmodule

// File: rtl/crossMulStage.sv
// Recursive WxW unsigned multiplier; W must be a power of two, at least 2.
module crossMulStage #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (W == 2) begin : g_base
      crossCell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
      logic [W-1:0] pLoLo, pLoHi, pHiLo, pHiHi;
      logic [W:0]   midSum;

      crossMulStage #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pLoLo));
      crossMulStage #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pLoHi));
      crossMulStage #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pHiLo));
      crossMulStage #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pHiHi));

      always_comb begin
        midSum = {1'b0, pLoHi} + {1'b0, pHiLo};
        p      = {pHiHi, pLoLo} + {{(H-1){1'b0}}, midSum, {H{1'b0}}};
      end
    end
  endgenerate
endmodule

// File: rtl/urdhvaMacCtrl.sv
module urdhvaMacCtrl
  import urdhvaMacPkg::*;
(
  input  logic        inValid,
  input  logic        accEn,
  input  logic        accClear,
  output macStrobes_t strobes
);
  always_comb begin
    strobes.loadProd = inValid;
    strobes.zeroAcc  = accClear;
    strobes.addAcc   = inValid & accEn & ~accClear;
  end
endmodule

// File: rtl/urdhvaMacDatapath.sv
module urdhvaMacDatapath
  import urdhvaMacPkg::*;
#(
  parameter int DATA_W = OPERAND_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  macStrobes_t           strobes,
  output logic [2*DATA_W-1:0]   product,
  output logic [2*DATA_W-1:0]   accum,
  output logic                  outValid
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] rawProd;
  logic [PROD_W-1:0] prodQ, accQ;
  logic              validQ;

  crossMulStage #(.W(DATA_W)) u_mul (.a(opA), .b(opB), .p(rawProd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ  <= '0;
      accQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.loadProd;
      if (strobes.loadProd) prodQ <= rawProd;
      if (strobes.zeroAcc)     accQ <= '0;
      else if (strobes.addAcc) accQ <= accQ + rawProd;
    end
  end

  assign product  = prodQ;
  assign accum    = accQ;
  assign outValid = validQ;
endmodule

// File: rtl/urdhvaMac.sv
module urdhvaMac
  import urdhvaMacPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [OPERAND_W-1:0]  opA,
  input  logic [OPERAND_W-1:0]  opB,
  input  logic                  inValid,
  input  logic                  accEn,
  input  logic                  accClear,
  output logic [RESULT_W-1:0]   product,
  output logic [RESULT_W-1:0]   accum,
  output logic                  outValid
);
  macStrobes_t strobes;

  urdhvaMacCtrl u_ctrl (
    .inValid(inValid), .accEn(accEn), .accClear(accClear), .strobes(strobes)
  );

  urdhvaMacDatapath #(.DATA_W(OPERAND_W)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .strobes(strobes),
    .product(product), .accum(accum), .outValid(outValid)
  );
endmodule

// File: rtl/urdhvaMacChecker.sv
module urdhvaMacChecker
  import urdhvaMacPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [OPERAND_W-1:0] opA,
  input logic [OPERAND_W-1:0] opB,
  input logic                 inValid,
  input logic                 accEn,
  input logic                 accClear,
  input logic [RESULT_W-1:0]  product,
  input logic [RESULT_W-1:0]  accum,
  input logic                 outValid
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (accum == '0) || !$past(!rstN)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R2
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN) (inValid && (opA == '0 || opB == '0)) |=> product == '0); // R8
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> $stable(product)); // R3
  AST_ACC_SUM: assert property (@(posedge clk) disable iff (!rstN) (inValid && accEn && !accClear) |=> accum == $past(accum) + product); // R4
  AST_ACC_SKIP: assert property (@(posedge clk) disable iff (!rstN) (inValid && !accEn && !accClear) |=> $stable(accum)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN) accClear |=> accum == '0); // R6
  AST_IDLE_ENABLE: assert property (@(posedge clk) disable iff (!rstN) (!inValid && accEn && !accClear) |=> $stable(accum)); // R7
endmodule

bind urdhvaMac urdhvaMacChecker u_chk (.*);

// File: tb/urdhvaMac_tb.sv
module urdhvaMac_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] opA, opB;
  logic        inValid, accEn, accClear;
  logic [31:0] product, accum;
  logic        outValid;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;
  bit finished = 0;
  string curTag = "R1";

  logic [31:0] mProd, mAcc;
  logic        mValid;

  always #2.5 clk = ~clk;

  urdhvaMac u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .inValid(inValid),
    .accEn(accEn), .accClear(accClear), .product(product), .accum(accum),
    .outValid(outValid)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mProd <= 0; mAcc <= 0; mValid <= 0;
    end else begin
      mValid <= inValid;
      if (inValid) mProd <= 32'(opA) * 32'(opB);
      if (accClear) mAcc <= 0;
      else if (inValid && accEn) mAcc <= mAcc + 32'(opA) * 32'(opB);
    end
  end

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal(curTag, "product", product, mProd);
    checkVal(curTag, "accum", accum, mAcc);
    checkVal(curTag, "outValid", 32'(outValid), 32'(mValid));
  endtask

  task automatic drive(logic [15:0] a, logic [15:0] b, logic v, logic e, logic c, string tag);
    opA = a; opB = b; inValid = v; accEn = e; accClear = c; curTag = tag;
    @(negedge clk);
    compareAll();
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000 && !finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycleCount);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 0; opA = 0; opB = 0; inValid = 0; accEn = 0; accClear = 0;
    repeat (3) @(negedge clk);
    checkVal("R1", "product in reset", product, 0);
    checkVal("R1", "accum in reset", accum, 0);
    checkVal("R1", "outValid in reset", 32'(outValid), 0);
    rstN = 1;
    @(negedge clk);
    compareAll();

    // R8 corner operands
    drive(16'd252, 16'd846, 1, 0, 0, "R8");
    checkVal("R8", "252x846", product, 32'd213192);
    drive(16'hFFFF, 16'hFFFF, 1, 0, 0, "R8");
    checkVal("R8", "FFFFxFFFF", product, 32'hFFFE0001);
    drive(16'hFFFF, 16'h0000, 1, 0, 0, "R8");
    checkVal("R8", "FFFFx0", product, 32'h0);
    drive(16'h0001, 16'hFFFF, 1, 0, 0, "R2");
    drive(16'hFFFF, 16'h0001, 1, 0, 0, "R2");
    drive(16'h0001, 16'h0001, 1, 0, 0, "R2");
    drive(16'h8000, 16'h8000, 1, 0, 0, "R2");
    drive(16'hAAAA, 16'h5555, 1, 0, 0, "R2");

    // R3 hold with valid low
    drive(16'h1234, 16'h4321, 0, 0, 0, "R3");
    drive(16'h0F0F, 16'hF0F0, 0, 0, 0, "R3");

    // R4 accumulate
    drive(16'd3, 16'd7, 1, 1, 0, "R4");
    drive(16'd100, 16'd200, 1, 1, 0, "R4");
    drive(16'd252, 16'd846, 1, 1, 0, "R4");
    // R5 valid without enable
    drive(16'd999, 16'd999, 1, 0, 0, "R5");
    // R7 enable without valid
    drive(16'hFFFF, 16'hFFFF, 0, 1, 0, "R7");
    drive(16'h1111, 16'h2222, 0, 1, 0, "R7");
    // R6 clear alone, then clear colliding with accumulate
    drive(16'd5, 16'd5, 1, 1, 0, "R6");
    drive(16'd0, 16'd0, 0, 0, 1, "R6");
    checkVal("R6", "accum after clear", accum, 0);
    drive(16'd40, 16'd40, 1, 1, 0, "R6");
    drive(16'd77, 16'd11, 1, 1, 1, "R6");
    checkVal("R6", "clear beats accumulate", accum, 0);
    checkVal("R6", "product loaded under clear", product, 32'd847);

    // R9 wrap-around
    drive(16'h0, 16'h0, 0, 0, 1, "R9");
    drive(16'hFFFF, 16'hFFFF, 1, 1, 0, "R9");
    drive(16'hFFFF, 16'hFFFF, 1, 1, 0, "R9");
    drive(16'hFFFF, 16'hFFFF, 1, 1, 0, "R9");
    checkVal("R9", "wrapped accum", accum, 32'hFFFA0003);

    // Randomised stream: all strobes toggle independently (R4, R6 collisions)
    for (int i = 0; i < 400; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 8) == 0, "R4");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule